// File: doc/BRIEF.md
# Multiplierless 8-Point Forward DCT Core

This block takes eight signed samples at once and returns the eight coefficients of their one-dimensional forward discrete cosine transform, scaled by integer constants. The first pipeline stage folds the vector into four pair-sums and four pair-differences. The second stage multiplies each of them by the constants it needs. The third stage combines the products with their signs, rounds the result and clamps it to the output width. Every constant product is a fixed network of shifts, additions and subtractions built from the constant's canonical signed-digit recoding. The block contains no general multiplier.

The core is intended as one pass of a row/column two-dimensional transform. With the default widths it takes level-shifted 8-bit pixels and delivers 12-bit signed coefficients. It accepts a new vector on every cycle where `in_valid` is high. The valid flag travels through the pipeline alongside the data. No other control exists at the block's edge.

Top module: `dct8_core`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result emerges, `out_valid` is 0 and every output lane is 0.
- R2: Input sample n (0..7) is the signed two's-complement field `in_vec[n*IN_W +: IN_W]`. Coefficient k (0..7) is the signed field `out_vec[k*OUT_W +: OUT_W]`.
- R3: Let s_j = x_j + x_(7-j) for j = 0..3. Before rounding, the even coefficients 0, 2, 4 and 6 are the s-vector dotted with the following rows, using a=64, b=83, d=36:
  - coefficient 0: (a, a, a, a)
  - coefficient 2: (b, d, -d, -b)
  - coefficient 4: (a, -a, -a, a)
  - coefficient 6: (d, -b, b, -d)
- R4: Let t_j = x_j - x_(7-j). Before rounding, the odd coefficients 1, 3, 5 and 7 are the t-vector dotted with the following rows, using c=89, e=75, f=50, g=18:
  - coefficient 1: (c, e, f, g)
  - coefficient 3: (e, -g, -c, -f)
  - coefficient 5: (f, -c, g, e)
  - coefficient 7: (g, -f, e, -c)
- R5: Each raw sum is rounded by adding 2^(SHIFT-1) and then shifting arithmetically right by SHIFT. The default SHIFT is 5, so 89 gives 3 and -64 gives -2.
- R6: A rounded value above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, and one below -2^(OUT_W-1) is output as -2^(OUT_W-1).
- R7: A vector presented with `in_valid` high before clock edge N appears on `out_vec`, with `out_valid` high, right after edge N+2. `out_valid` equals `in_valid` delayed by three edges.
- R8: Vectors presented on consecutive cycles each produce their own result on consecutive cycles, in order.
- R9: `out_vec` holds its last value whenever `out_valid` is low. A vector presented with `in_valid` low changes no output.
- R10: A mirror-symmetric input (x_n = x_(7-n)) gives zero on all odd coefficients. A mirror-antisymmetric input (x_n = -x_(7-n)) gives zero on all even coefficients.
- R11: When no clamping occurs, each coefficient lies within 40 output LSBs of the real-valued transform. That transform is scaled by 64·√2·2^-SHIFT for k>0 and by 64·2^-SHIFT for k=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_vec` as a vector to transform |
| in_vec | input | 8*IN_W | Eight signed samples, sample n at bits n*IN_W |
| out_valid | output | 1 | Marks `out_vec` as a fresh result |
| out_vec | output | 8*OUT_W | Eight signed coefficients, coefficient k at bits k*OUT_W |

## Verification
The core is driven with four kinds of input, each aimed at a different fault:
- All-zero and all-extreme vectors bound the dynamic range. With a second instance built with a smaller shift, the extreme vectors force clamping at both ends.
- Single-sample impulses of either sign isolate one column of the constant matrix, which exposes a wrong constant, sign or lane position. They also show how the rounding treats negative values.
- Mirror-symmetric and antisymmetric vectors separate the even path from the odd path.
- Long random runs with random gaps in the valid flag, plus a back-to-back burst, expose latency slips, data reordering and outputs that change on cycles with no result.

Every result is compared with an exact integer model in the bench. The results of the default instance are also compared with a real-valued cosine transform.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int NPT    = 8;   // samples per vector
    localparam int HALF   = 4;   // folded half length
    localparam int NCONST = 7;   // distinct constants
    localparam int NEVEN  = 3;   // constants 0..2 act on sums, 3..6 on differences
    localparam int CMAX_W = 8;   // magnitude width of the largest constant

    // Scaled cosine constants: 0:a 1:b 2:d | 3:c 4:e 5:f 6:g
    function automatic int kval(input int id);
        case (id)
            0: return 64;
            1: return 83;
            2: return 36;
            3: return 89;
            4: return 75;
            5: return 50;
            6: return 18;
            default: return 0;
        endcase
    endfunction

    // Which constant multiplies folded term j for output k
    function automatic int tap_id(input int k, input int j);
        int ids [HALF];
        case (k)
            0: ids = '{0, 0, 0, 0};
            2: ids = '{1, 2, 2, 1};
            4: ids = '{0, 0, 0, 0};
            6: ids = '{2, 1, 1, 2};
            1: ids = '{3, 4, 5, 6};
            3: ids = '{4, 6, 3, 5};
            5: ids = '{5, 3, 6, 4};
            default: ids = '{6, 5, 4, 3};
        endcase
        return ids[j];
    endfunction

    // Sign of that product; bit j set means subtract
    function automatic logic tap_neg(input int k, input int j);
        logic [HALF-1:0] m;
        case (k)
            2: m = 4'b1100;
            4: m = 4'b0110;
            6: m = 4'b1010;
            3: m = 4'b1110;
            5: m = 4'b0010;
            7: m = 4'b1010;
            default: m = 4'b0000;
        endcase
        return m[j];
    endfunction

    // Constant product as a shift/add network from the non-adjacent
    // signed-digit recoding of k (k is elaboration-constant at every call)
    function automatic logic signed [31:0] csd_mult(input logic signed [31:0] x,
                                                    input int k);
        logic signed [31:0] acc;
        int r;
        acc = '0;
        r   = k;
        for (int i = 0; i <= CMAX_W; i++) begin
            if (r[0]) begin
                if (r[1]) begin
                    acc = acc - (x <<< i);
                    r   = r + 1;
                end else begin
                    acc = acc + (x <<< i);
                    r   = r - 1;
                end
            end
            r = r >>> 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/dct8_butterfly.sv
module dct8_butterfly
    import dct8_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vld_i,
    input  logic [NPT*IN_W-1:0]          x_i,
    output logic                         vld_o,
    output logic [HALF-1:0][IN_W:0]      sum_o,
    output logic [HALF-1:0][IN_W:0]      dif_o
);
    localparam int SW = IN_W + 1;

    typedef struct packed {
        logic                   vld;
        logic [HALF-1:0][SW-1:0] s;
        logic [HALF-1:0][SW-1:0] d;
    } bfly_t;

    bfly_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            for (int j = 0; j < HALF; j++) begin
                st_d.s[j] = SW'($signed(x_i[j*IN_W +: IN_W]))
                          + SW'($signed(x_i[(NPT-1-j)*IN_W +: IN_W]));
                st_d.d[j] = SW'($signed(x_i[j*IN_W +: IN_W]))
                          - SW'($signed(x_i[(NPT-1-j)*IN_W +: IN_W]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign sum_o = st_q.s;
    assign dif_o = st_q.d;

endmodule

// File: rtl/dct8_cmul.sv
module dct8_cmul
    import dct8_pkg::*;
#(
    parameter int SW = 9,
    parameter int PW = SW + CMAX_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                vld_i,
    input  logic [HALF-1:0][SW-1:0]             sum_i,
    input  logic [HALF-1:0][SW-1:0]             dif_i,
    output logic                                vld_o,
    output logic [NCONST-1:0][HALF-1:0][PW-1:0] prod_o
);
    typedef struct packed {
        logic                                vld;
        logic [NCONST-1:0][HALF-1:0][PW-1:0] p;
    } mul_t;

    mul_t st_d, st_q;
    logic [NCONST-1:0][HALF-1:0][PW-1:0] p_c;

    for (genvar c = 0; c < NCONST; c++) begin : g_const
        for (genvar j = 0; j < HALF; j++) begin : g_term
            logic signed [SW-1:0] src;
            if (c < NEVEN) begin : g_even
                assign src = $signed(sum_i[j]);
            end else begin : g_odd
                assign src = $signed(dif_i[j]);
            end
            assign p_c[c][j] = PW'(csd_mult(32'(src), kval(c)));
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.p = p_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign prod_o = st_q.p;

endmodule

// File: rtl/dct8_combine.sv
module dct8_combine
    import dct8_pkg::*;
#(
    parameter int PW    = 17,
    parameter int OUT_W = 12,
    parameter int SHIFT = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                vld_i,
    input  logic [NCONST-1:0][HALF-1:0][PW-1:0] prod_i,
    output logic                                vld_o,
    output logic [NPT-1:0][OUT_W-1:0]           y_o
);
    localparam int AW = PW + 2;
    localparam logic signed [AW:0] RND  = (AW+1)'((1 << SHIFT) >> 1);
    localparam logic signed [AW:0] MAXV = (AW+1)'((1 << (OUT_W-1)) - 1);
    localparam logic signed [AW:0] MINV = -(AW+1)'(1 << (OUT_W-1));

    typedef struct packed {
        logic                         vld;
        logic [NPT-1:0][OUT_W-1:0]    y;
    } out_t;

    out_t st_d, st_q;
    logic [NPT-1:0][OUT_W-1:0] y_c;

    for (genvar k = 0; k < NPT; k++) begin : g_lane
        logic signed [AW:0]    acc;
        logic signed [AW:0]    scaled;
        logic [OUT_W-1:0]      lane;
        always_comb begin
            acc = '0;
            for (int j = 0; j < HALF; j++) begin
                if (tap_neg(k, j))
                    acc = acc - (AW+1)'($signed(prod_i[tap_id(k, j)][j]));
                else
                    acc = acc + (AW+1)'($signed(prod_i[tap_id(k, j)][j]));
            end
            scaled = (acc + RND) >>> SHIFT;
            if (scaled > MAXV)      lane = MAXV[OUT_W-1:0];
            else if (scaled < MINV) lane = MINV[OUT_W-1:0];
            else                    lane = scaled[OUT_W-1:0];
        end
        assign y_c[k] = lane;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.y = y_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign y_o   = st_q.y;

endmodule

// File: rtl/dct8_core.sv
module dct8_core
    import dct8_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12,
    parameter int SHIFT = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NPT*IN_W-1:0]     in_vec,
    output logic                    out_valid,
    output logic [NPT*OUT_W-1:0]    out_vec
);
    localparam int SW = IN_W + 1;
    localparam int PW = SW + CMAX_W;

    logic                                bf_vld;
    logic [HALF-1:0][SW-1:0]             bf_sum;
    logic [HALF-1:0][SW-1:0]             bf_dif;
    logic                                mu_vld;
    logic [NCONST-1:0][HALF-1:0][PW-1:0] mu_prod;
    logic [NPT-1:0][OUT_W-1:0]           cb_y;

    dct8_butterfly #(.IN_W(IN_W)) u_bfly (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .x_i   (in_vec),
        .vld_o (bf_vld),
        .sum_o (bf_sum),
        .dif_o (bf_dif)
    );

    dct8_cmul #(.SW(SW), .PW(PW)) u_cmul (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (bf_vld),
        .sum_i  (bf_sum),
        .dif_i  (bf_dif),
        .vld_o  (mu_vld),
        .prod_o (mu_prod)
    );

    dct8_combine #(.PW(PW), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (mu_vld),
        .prod_i (mu_prod),
        .vld_o  (out_valid),
        .y_o    (cb_y)
    );

    assign out_vec = cb_y;

endmodule

// File: rtl/dct8_core_chk.sv
module dct8_core_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12,
    parameter int SHIFT = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [8*IN_W-1:0]     in_vec,
    input logic                  out_valid,
    input logic [8*OUT_W-1:0]    out_vec
);
    logic [1:0] warm_cnt;
    logic       warm;
    logic       in_sym, in_anti, odd_zero, even_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    always_comb begin
        in_sym  = 1'b1;
        in_anti = 1'b1;
        for (int j = 0; j < 4; j++) begin
            if (in_vec[j*IN_W +: IN_W] != in_vec[(7-j)*IN_W +: IN_W]) in_sym = 1'b0;
            if ((IN_W+1)'($signed(in_vec[j*IN_W +: IN_W]))
              + (IN_W+1)'($signed(in_vec[(7-j)*IN_W +: IN_W])) != '0) in_anti = 1'b0;
        end
        odd_zero  = 1'b1;
        even_zero = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (out_vec[k*OUT_W +: OUT_W] != '0) begin
                if (k % 2 == 1) odd_zero  = 1'b0;
                else            even_zero = 1'b0;
            end
        end
    end

    // R7: result flag trails the input flag by three edges
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R9: no result, no change on the coefficient bus
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_vec));

    // R10: mirror-symmetric input leaves the odd path at zero
    a_r10_sym_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_sym, 3)) |-> odd_zero);

    // R10: antisymmetric input leaves the even path at zero
    a_r10_anti_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_anti, 3)) |-> even_zero);

endmodule

bind dct8_core dct8_core_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/dct8_core_bench.sv
module dct8_core_bench;
    localparam int IN_W      = 8;
    localparam int OUT_W     = 12;
    localparam int SHIFT     = 5;
    localparam int SAT_SHIFT = 3;
    localparam int NL        = 8;
    localparam int VW        = NL * IN_W;
    localparam int YW        = NL * OUT_W;
    localparam real TOL      = 40.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          out_valid, sat_valid;
    logic [YW-1:0] out_vec, sat_vec;

    always #10 clk = ~clk;   // 50 MHz

    dct8_core #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_dct8_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec));

    // second build with a small shift so that clamping is reachable (R6)
    dct8_core #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SAT_SHIFT)) u_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(sat_valid), .out_vec(sat_vec));

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic          hv [3];
    logic [VW-1:0] hx [3];
    string         ht [3];
    logic [YW-1:0] exp_main = '0;
    logic [YW-1:0] exp_sat  = '0;

    // integer cosine table folded by quarter-wave symmetry
    function automatic int coef(input int k, input int n);
        int tbl [9] = '{0, 89, 83, 75, 64, 50, 36, 18, 0};
        int q;
        if (k == 0) return 64;
        q = (k * (2*n + 1)) % 32;
        if (q > 16) q = 32 - q;
        if (q > 8) return -tbl[16 - q];
        return tbl[q];
    endfunction

    function automatic int xin(input logic [VW-1:0] v, input int n);
        return int'($signed(v[n*IN_W +: IN_W]));
    endfunction

    function automatic logic [YW-1:0] model(input logic [VW-1:0] v, input int sh);
        logic [YW-1:0] r;
        int acc, y, hi, lo;
        hi = (1 << (OUT_W-1)) - 1;
        lo = -(1 << (OUT_W-1));
        for (int k = 0; k < NL; k++) begin
            acc = 0;
            for (int n = 0; n < NL; n++) acc += coef(k, n) * xin(v, n);
            y = (acc + ((1 << sh) >> 1)) >>> sh;
            if (y > hi) y = hi;
            if (y < lo) y = lo;
            r[k*OUT_W +: OUT_W] = OUT_W'(y);
        end
        return r;
    endfunction

    function automatic real fref(input logic [VW-1:0] v, input int k);
        real s, pi;
        pi = 3.14159265358979;
        s = 0.0;
        for (int n = 0; n < NL; n++)
            s += real'(xin(v, n)) * $cos(real'((2*n + 1) * k) * pi / 16.0);
        s = s * 64.0 * ((k == 0) ? 1.0 : $sqrt(2.0));
        return s / real'(1 << SHIFT);
    endfunction

    function automatic logic [VW-1:0] pack(input int a [NL]);
        logic [VW-1:0] v;
        for (int n = 0; n < NL; n++) v[n*IN_W +: IN_W] = IN_W'(a[n]);
        return v;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int n = 0; n < NL; n++) v[n*IN_W +: IN_W] = IN_W'($urandom_range(0, 255));
        return v;
    endfunction

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic check_out();
        string tg;
        int a, e;
        real d;
        if (hv[2]) begin
            exp_main = model(hx[2], SHIFT);
            exp_sat  = model(hx[2], SAT_SHIFT);
        end
        total++;  // R7 flag timing
        if (out_valid !== hv[2]) fail_line("R7", "out_valid", int'(out_valid), int'(hv[2]));
        total++;
        if (sat_valid !== hv[2]) fail_line("R7", "sat out_valid", int'(sat_valid), int'(hv[2]));
        for (int k = 0; k < NL; k++) begin
            if (!hv[2])          tg = "R9";
            else if (ht[2] != "") tg = ht[2];
            else                 tg = (k % 2 == 1) ? "R4" : "R3";
            a = int'($signed(out_vec[k*OUT_W +: OUT_W]));
            e = int'($signed(exp_main[k*OUT_W +: OUT_W]));
            total++;
            if (a != e) fail_line(tg, $sformatf("lane %0d", k), a, e);
            a = int'($signed(sat_vec[k*OUT_W +: OUT_W]));
            e = int'($signed(exp_sat[k*OUT_W +: OUT_W]));
            total++;
            if (a != e) fail_line("R6", $sformatf("clamped build lane %0d", k), a, e);
            if (hv[2]) begin
                a = int'($signed(out_vec[k*OUT_W +: OUT_W]));
                d = real'(a) - fref(hx[2], k);
                if (d < 0.0) d = -d;
                total++;
                if (d > TOL) fail_line("R11", $sformatf("real-valued lane %0d", k),
                                       a, int'(fref(hx[2], k)));
            end
        end
    endtask

    task automatic step(input logic v, input logic [VW-1:0] x, input string tag);
        @(negedge clk);
        check_out();
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1];
            hx[i] = hx[i-1];
            ht[i] = ht[i-1];
        end
        hv[0] = v;
        hx[0] = x;
        ht[0] = tag;
        in_valid = v;
        in_vec   = x;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int a [NL];
        logic [VW-1:0] v;
        void'($urandom(32'd20241));
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0;
            hx[i] = '0;
            ht[i] = "";
        end

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0 || out_vec !== '0)
                fail_line("R1", "reset outputs", int'(out_vec[OUT_W-1:0]), 0);
        end
        rst_n = 1'b1;
        step(1'b0, rnd_vec(), "R1");
        step(1'b0, rnd_vec(), "R1");

        // directed corners
        a = '{0, 0, 0, 0, 0, 0, 0, 0};             step(1'b1, pack(a), "R3");
        a = '{127, 127, 127, 127, 127, 127, 127, 127}; step(1'b1, pack(a), "R6");
        a = '{-128, -128, -128, -128, -128, -128, -128, -128}; step(1'b1, pack(a), "R6");
        a = '{127, -128, 127, -128, 127, -128, 127, -128}; step(1'b1, pack(a), "R6");
        a = '{1, 0, 0, 0, 0, 0, 0, 0};             step(1'b1, pack(a), "R5");
        a = '{-1, 0, 0, 0, 0, 0, 0, 0};            step(1'b1, pack(a), "R5");
        a = '{0, 0, 0, -1, 0, 0, 0, 0};            step(1'b1, pack(a), "R5");
        a = '{0, 0, 0, 0, 0, 100, 0, 0};           step(1'b1, pack(a), "R2");
        a = '{0, -77, 0, 0, 0, 0, 0, 0};           step(1'b1, pack(a), "R2");
        for (int r = 0; r < 4; r++) begin
            v = rnd_vec();
            for (int j = 0; j < 4; j++) v[(7-j)*IN_W +: IN_W] = v[j*IN_W +: IN_W];
            step(1'b1, v, "R10");
        end
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 4; j++) begin
                a[j]     = int'($urandom_range(0, 254)) - 127;
                a[7 - j] = -a[j];
            end
            step(1'b1, pack(a), "R10");
        end
        // R9: idle vectors with junk data
        for (int r = 0; r < 4; r++) step(1'b0, rnd_vec(), "R9");
        // R8: back-to-back burst
        for (int r = 0; r < 12; r++) step(1'b1, rnd_vec(), "R8");
        // random traffic with gaps
        for (int r = 0; r < 600; r++) step(($urandom_range(0, 3) != 0), rnd_vec(), "");
        for (int r = 0; r < 5; r++) step(1'b0, rnd_vec(), "R9");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule